// File: doc/BRIEF.md
# Start-Up Event Sequencer

This block governs the hand-over from configuration loading to normal user operation. Once loading has finished, a single start request sets off three events. The DONE indication rises. The I/O outputs leave their high-impedance state. The global set/reset that has been holding every user flip-flop is released. Each event has its own 2-bit slot option. The option places that event in a short window of clock periods that opens on the clock edge which accepts the start request. Because of this the three events can come in any order, in the same clock, or one clock apart.

A mode option picks the timing clock for the whole sequence. The first choice is the configuration clock, which runs independently of the system clock. The second choice is a user clock. In user-clock mode the start request crosses into the user-clock domain through a two-stage synchronizer, and the slot counting runs on that clock. The mode and the slot options are sampled when the start is accepted. Only the first start after reset has any effect. A slot code beyond the window is pulled back to the last slot.

Top module: `sus_startup_seq`

## Requirements
- R1: While rst_n is low, and after reset until an event is scheduled, done_o is 0, io_en_o is 0 and gsr_o is 1. Pulling rst_n low in the middle of a sequence returns the outputs to this state.
- R2: In configuration-clock mode (usr_sync_i = 0 when start is accepted), consider an event whose slot code is k, with k = 0, 1 or 2. The event takes effect right after the k-th cfg_clk rising edge that follows the edge sampling start_i high. For k = 0 this is the sampling edge itself. done_slot_i times the rise of done_o, io_slot_i times the rise of io_en_o, and gsr_slot_i times the fall of gsr_o.
- R3: A slot code of 3 lies outside the three-slot window and is treated as slot 2.
- R4: The three slot options act independently. Any order of events is possible, and events with equal slots change on the same edge.
- R5: Once an event has taken effect, its output holds that value until reset.
- R6: In user-clock mode (usr_sync_i = 1 when start is accepted), an event with slot code k takes effect right after the (k+3)-th usr_clk rising edge that follows the cfg_clk edge accepting start. The configuration-clock timer stays idle.
- R7: The mode and the three slot codes are captured on the edge that accepts start. Changing them afterwards has no effect on the running sequence.
- R8: Holding start_i high, or raising it again after the sequence has begun, neither restarts nor delays the sequence.
- R9: Without a start request the outputs remain in their reset state, whatever the option inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_clk | input | 1 | Configuration clock; also times the sequence in its own mode |
| usr_clk | input | 1 | User clock; times the sequence in user-clock mode |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| start_i | input | 1 | Loading complete; sampled on cfg_clk |
| usr_sync_i | input | 1 | 0: time on cfg_clk, 1: synchronize to usr_clk |
| done_slot_i | input | 2 | Slot code for the DONE rise |
| io_slot_i | input | 2 | Slot code for the I/O enable |
| gsr_slot_i | input | 2 | Slot code for the set/reset release |
| done_o | output | 1 | DONE indication, 1 once reached |
| io_en_o | output | 1 | 1 lets the user I/O drive; 0 keeps them high-impedance |
| gsr_o | output | 1 | 1 holds the global set/reset; 0 once released |

## Verification
The hardest situation to reach is user-clock mode. There the event times depend on where the start edge falls against a second, unrelated clock, and a coincident edge would make the expected count ambiguous. The stimulus runs the two clocks at 5 ns and 7 ns with phases chosen so that their rising edges never meet. The bench anchors its count on the first user-clock edge after the accepting configuration edge. In every run, once start has been accepted, the bench inverts all option inputs and the mode. It also keeps start high or re-pulses it, so the timing it measures must come from the captured settings alone.

// File: rtl/sus_pkg.sv
`timescale 1ns/100ps
package sus_pkg;
    localparam int SUS_NUM_EVT   = 3;
    localparam int SUS_SLOT_W    = 2;
    localparam int SUS_NUM_SLOTS = 3;

    // event positions inside the event vectors
    localparam int EVT_DONE = 0;
    localparam int EVT_IOEN = 1;
    localparam int EVT_REL  = 2;

    typedef enum logic {
        TIME_CFG = 1'b0,
        TIME_USR = 1'b1
    } sus_timing_e;
endpackage

// File: rtl/sus_slot_clamp.sv
`timescale 1ns/100ps
module sus_slot_clamp #(
    parameter int NUM_EVT   = sus_pkg::SUS_NUM_EVT,
    parameter int SLOT_W    = sus_pkg::SUS_SLOT_W,
    parameter int NUM_SLOTS = sus_pkg::SUS_NUM_SLOTS
) (
    input  logic [NUM_EVT-1:0][SLOT_W-1:0] raw_i,
    output logic [NUM_EVT-1:0][SLOT_W-1:0] legal_o
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

    // codes past the window fall back to the final slot
    for (genvar e = 0; e < NUM_EVT; e++) begin : g_clamp
        assign legal_o[e] = (raw_i[e] > LAST) ? LAST : raw_i[e];
    end
endmodule

// File: rtl/sus_pulse_sync.sv
`timescale 1ns/100ps
module sus_pulse_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic pulse_o
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d      = sy_q;
        sy_d.sh   = {sy_q.sh[STAGES-2:0], lvl_i};
        sy_d.prev = sy_q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    // rising edge of the synchronized level
    assign pulse_o = sy_q.sh[STAGES-1] & ~sy_q.prev;

    AST_SYNC_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);  // R6
endmodule

// File: rtl/sus_slot_timer.sv
`timescale 1ns/100ps
module sus_slot_timer #(
    parameter int NUM_EVT   = sus_pkg::SUS_NUM_EVT,
    parameter int SLOT_W    = sus_pkg::SUS_SLOT_W,
    parameter int NUM_SLOTS = sus_pkg::SUS_NUM_SLOTS
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start_i,
    input  logic [NUM_EVT-1:0][SLOT_W-1:0] slot_i,
    output logic [NUM_EVT-1:0]             ev_o
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);
    localparam logic [SLOT_W-1:0] ONE  = SLOT_W'(1);

    typedef struct packed {
        logic                           begun;
        logic                           active;
        logic [SLOT_W-1:0]              cnt;
        logic [NUM_EVT-1:0][SLOT_W-1:0] slot;
        logic [NUM_EVT-1:0]             ev;
    } tmr_t;

    tmr_t tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        if (!tm_q.begun && start_i) begin
            // the accepting edge is slot 0
            tm_d.begun  = 1'b1;
            tm_d.active = (LAST != '0);
            tm_d.cnt    = ONE;
            tm_d.slot   = slot_i;
            for (int e = 0; e < NUM_EVT; e++) begin
                tm_d.ev[e] = (slot_i[e] == '0);
            end
        end else if (tm_q.active) begin
            for (int e = 0; e < NUM_EVT; e++) begin
                if (tm_q.cnt == tm_q.slot[e]) tm_d.ev[e] = 1'b1;
            end
            if (tm_q.cnt == LAST) tm_d.active = 1'b0;
            else                  tm_d.cnt    = tm_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    assign ev_o = tm_q.ev;

    for (genvar e = 0; e < NUM_EVT; e++) begin : g_chk
        AST_EVENT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            tm_q.ev[e] |=> tm_q.ev[e]);  // R5
        AST_EVENT_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
            (tm_q.active && (tm_q.cnt <= tm_q.slot[e])) |-> !tm_q.ev[e]);  // R2
        AST_SLOT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
            tm_q.begun |-> (tm_q.slot[e] <= LAST));  // R3
    end

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        tm_q.begun |=> (tm_q.begun && $stable(tm_q.slot)));  // R8
endmodule

// File: rtl/sus_startup_seq.sv
`timescale 1ns/100ps
module sus_startup_seq #(
    parameter int SLOT_W      = sus_pkg::SUS_SLOT_W,
    parameter int NUM_SLOTS   = sus_pkg::SUS_NUM_SLOTS,
    parameter int SYNC_STAGES = 2
) (
    input  logic              cfg_clk,
    input  logic              usr_clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              usr_sync_i,
    input  logic [SLOT_W-1:0] done_slot_i,
    input  logic [SLOT_W-1:0] io_slot_i,
    input  logic [SLOT_W-1:0] gsr_slot_i,
    output logic              done_o,
    output logic              io_en_o,
    output logic              gsr_o
);
    import sus_pkg::*;

    localparam int NUM_EVT = SUS_NUM_EVT;

    typedef struct packed {
        logic                           started;
        sus_timing_e                    mode;
        logic                           usr_req;
        logic [NUM_EVT-1:0][SLOT_W-1:0] slot;
    } front_t;

    logic [NUM_EVT-1:0][SLOT_W-1:0] raw_slot, legal_slot;
    logic [NUM_EVT-1:0]             cfg_ev, usr_ev, ev_sel;
    logic                           cfg_start, usr_start;
    front_t                         fr_d, fr_q;

    always_comb begin
        raw_slot           = '0;
        raw_slot[EVT_DONE] = done_slot_i;
        raw_slot[EVT_IOEN] = io_slot_i;
        raw_slot[EVT_REL]  = gsr_slot_i;
    end

    sus_slot_clamp #(
        .NUM_EVT   (NUM_EVT),
        .SLOT_W    (SLOT_W),
        .NUM_SLOTS (NUM_SLOTS)
    ) i_clamp (
        .raw_i   (raw_slot),
        .legal_o (legal_slot)
    );

    // configuration-domain front end: accepts the first start only
    always_comb begin
        fr_d = fr_q;
        if (!fr_q.started && start_i) begin
            fr_d.started = 1'b1;
            fr_d.mode    = sus_timing_e'(usr_sync_i);
            fr_d.usr_req = usr_sync_i;
            fr_d.slot    = legal_slot;
        end
    end

    always_ff @(posedge cfg_clk or negedge rst_n) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

    assign cfg_start = start_i & ~fr_q.started & ~usr_sync_i;

    sus_slot_timer #(
        .NUM_EVT   (NUM_EVT),
        .SLOT_W    (SLOT_W),
        .NUM_SLOTS (NUM_SLOTS)
    ) i_cfg_timer (
        .clk     (cfg_clk),
        .rst_n   (rst_n),
        .start_i (cfg_start),
        .slot_i  (legal_slot),
        .ev_o    (cfg_ev)
    );

    sus_pulse_sync #(
        .STAGES (SYNC_STAGES)
    ) i_usr_sync (
        .clk     (usr_clk),
        .rst_n   (rst_n),
        .lvl_i   (fr_q.usr_req),
        .pulse_o (usr_start)
    );

    // slots were captured in the front end and are settled before use here
    sus_slot_timer #(
        .NUM_EVT   (NUM_EVT),
        .SLOT_W    (SLOT_W),
        .NUM_SLOTS (NUM_SLOTS)
    ) i_usr_timer (
        .clk     (usr_clk),
        .rst_n   (rst_n),
        .start_i (usr_start),
        .slot_i  (fr_q.slot),
        .ev_o    (usr_ev)
    );

    assign ev_sel  = (fr_q.mode == TIME_USR) ? usr_ev : cfg_ev;
    assign done_o  = ev_sel[EVT_DONE];
    assign io_en_o = ev_sel[EVT_IOEN];
    assign gsr_o   = ~ev_sel[EVT_REL];

    AST_MODE_HELD: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        fr_q.started |=> (fr_q.started && $stable(fr_q.mode) && $stable(fr_q.slot)));  // R7
    AST_CFG_PATH_QUIET: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (fr_q.mode == TIME_USR) |-> (cfg_ev == '0));  // R6
    AST_IDLE_BEFORE_START: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        !fr_q.started |-> (!done_o && !io_en_o && gsr_o));  // R9
endmodule

// File: tb/test_sus_startup_seq.sv
`timescale 1ns/100ps
module test_sus_startup_seq;
    logic       cfg_clk = 1'b0;
    logic       usr_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       usr_sync_i = 1'b0;
    logic [1:0] d_s = 2'd0, i_s = 2'd0, g_s = 2'd0;
    logic       done_o, io_en_o, gsr_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    sus_startup_seq i_sus_startup_seq (
        .cfg_clk     (cfg_clk),
        .usr_clk     (usr_clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .usr_sync_i  (usr_sync_i),
        .done_slot_i (d_s),
        .io_slot_i   (i_s),
        .gsr_slot_i  (g_s),
        .done_o      (done_o),
        .io_en_o     (io_en_o),
        .gsr_o       (gsr_o)
    );

    // 200 MHz configuration clock: rising edges at 2.5 + 5n ns
    initial forever #2.5 cfg_clk = ~cfg_clk;
    // user clock, 7 ns: rising edges at whole ns, never on a cfg_clk edge
    initial begin
        #4;
        forever begin
            usr_clk = 1'b1; #3.5;
            usr_clk = 1'b0; #3.5;
        end
    end

    // fields: repulse, mode, done slot, io slot, release slot
    localparam int NV = 9;
    localparam logic [7:0] VEC [NV] = '{
        {1'b0, 1'b0, 2'd0, 2'd1, 2'd2},
        {1'b0, 1'b0, 2'd2, 2'd1, 2'd0},
        {1'b0, 1'b0, 2'd1, 2'd1, 2'd1},
        {1'b0, 1'b0, 2'd3, 2'd0, 2'd3},
        {1'b0, 1'b0, 2'd0, 2'd0, 2'd0},
        {1'b0, 1'b1, 2'd0, 2'd1, 2'd2},
        {1'b0, 1'b1, 2'd3, 2'd2, 2'd0},
        {1'b0, 1'b1, 2'd1, 2'd0, 2'd1},
        {1'b1, 1'b0, 2'd2, 2'd2, 2'd2}
    };
    string TAG [NV] = '{"R2 default", "R4 reversed", "R4 together", "R3 clamp",
                        "R2 all first", "R6 default", "R6 R3 clamp", "R6 mixed",
                        "R8 restart"};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_idx(input logic [1:0] s, input logic sel);
        int c;
        c = (s > 2'd2) ? 2 : int'(s);  // R3
        return c + (sel ? 2 : 0);      // R2 / R6
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        start_i = 1'b0;
        repeat (3) @(negedge cfg_clk);
        #1.5 rst_n = 1'b1;
        @(negedge cfg_clk);
    endtask

    task automatic run_seq(input logic [7:0] v, input string tag);
        logic rep, sel;
        int fd, fi, fg;
        rep = v[7];
        sel = v[6];
        fd = -1; fi = -1; fg = -1;
        do_reset();
        usr_sync_i = sel;
        d_s = v[5:4]; i_s = v[3:2]; g_s = v[1:0];
        start_i = 1'b1;
        @(posedge cfg_clk);
        if (sel) @(posedge usr_clk);
        for (int j = 0; j < 8; j++) begin
            if (sel) @(negedge usr_clk);
            else     @(negedge cfg_clk);
            if (done_o && fd < 0)  fd = j;
            if (io_en_o && fi < 0) fi = j;
            if (!gsr_o && fg < 0)  fg = j;
            if (j == 0) begin
                // R7: everything flips after acceptance
                d_s = ~v[5:4]; i_s = ~v[3:2]; g_s = ~v[1:0];
                usr_sync_i = ~sel;
            end
            start_i = rep ? (j == 0) : 1'b1;  // R8
        end
        chk(fd == exp_idx(v[5:4], sel), {tag, " R7 done_o timing"}, fd, exp_idx(v[5:4], sel));
        chk(fi == exp_idx(v[3:2], sel), {tag, " R7 io_en_o timing"}, fi, exp_idx(v[3:2], sel));
        chk(fg == exp_idx(v[1:0], sel), {tag, " R7 gsr_o timing"}, fg, exp_idx(v[1:0], sel));
        chk(done_o && io_en_o && !gsr_o, {tag, " R5 held"},
            int'({done_o, io_en_o, gsr_o}), 3'b110);
        start_i = 1'b0;
    endtask

    initial begin
        // R1: outputs idle during reset
        rst_n = 1'b0;
        repeat (2) @(negedge cfg_clk);
        chk(!done_o && io_en_o == 1'b0 && gsr_o, "R1 in reset",
            int'({done_o, io_en_o, gsr_o}), 3'b001);

        // R9: no start, various options, both modes
        do_reset();
        d_s = 2'd0; i_s = 2'd0; g_s = 2'd0; usr_sync_i = 1'b1;
        repeat (12) @(negedge cfg_clk);
        chk(!done_o && !io_en_o && gsr_o, "R9 idle user mode",
            int'({done_o, io_en_o, gsr_o}), 3'b001);
        usr_sync_i = 1'b0; d_s = 2'd3;
        repeat (12) @(negedge cfg_clk);
        chk(!done_o && !io_en_o && gsr_o, "R9 idle cfg mode",
            int'({done_o, io_en_o, gsr_o}), 3'b001);

        for (int k = 0; k < NV; k++) run_seq(VEC[k], TAG[k]);

        // R1: reset in the middle of a running sequence
        do_reset();
        usr_sync_i = 1'b0; d_s = 2'd0; i_s = 2'd0; g_s = 2'd2;
        start_i = 1'b1;
        @(posedge cfg_clk);
        @(negedge cfg_clk);
        start_i = 1'b0;
        chk(done_o && io_en_o && gsr_o, "R1 precondition mid-run",
            int'({done_o, io_en_o, gsr_o}), 3'b111);
        #1 rst_n = 1'b0;
        #1;
        chk(!done_o && !io_en_o && gsr_o, "R1 mid-run reset",
            int'({done_o, io_en_o, gsr_o}), 3'b001);
        repeat (2) @(negedge cfg_clk);
        #1.5 rst_n = 1'b1;
        repeat (6) @(negedge cfg_clk);
        chk(!done_o && !io_en_o && gsr_o, "R1 R9 after mid-run reset",
            int'({done_o, io_en_o, gsr_o}), 3'b001);

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1..all: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule